// File: doc/BRIEF.md
# Programmable-Priority Interrupt Resolver

This block picks one winner among a set of maskable interrupt requests. Each source carries a fixed rank set by its index, with index 0 ranked first. Software can promote any one source above the whole fixed chain by writing its number into a 5-bit select field of an 8-bit control register. The winning index and its vector address are presented combinationally, in the same cycle as the request inputs.

The CPU's global mask bit is an input to the block. While the mask is set, no request is presented. The select field also accepts writes only while the mask is set, so software can change the priority order only when interrupts are inhibited. The three upper register bits are plain storage with no effect on arbitration. Each source's vector depends on its index alone and never on which source is promoted.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset the control register reads 8'h06: select field (bits 4:0) = 5'b00110, bits 7:5 = 0.
- R2: A write while `gmask_i` is 1 loads all eight bits of `wr_data_i` into the control register, visible on `ctrl_o` after the next rising clock edge.
- R3: A write while `gmask_i` is 0 leaves the select field (bits 4:0) unchanged. Bits 7:5 still take the written data.
- R4: `irq_valid_o` is 1 exactly when `gmask_i` is 0 and at least one source has both `req_i[i]` and `en_i[i]` set. When it is 0, `irq_idx_o` and `irq_vec_o` are 0.
- R5: When the promoted source is not active, the winner is the active source with the lowest index.
- R6: When the source whose index equals the select field is requesting and enabled, and `gmask_i` is 0, that source wins over all others.
- R7: A promoted source with its enable clear, or any source while `gmask_i` is 1, is not presented. With the enable clear, arbitration falls back to the fixed order.
- R8: A select value of N_SRC or above promotes nothing, and the fixed order applies.
- R9: `irq_vec_o` equals VEC_TOP - 2*`irq_idx_o` whenever `irq_valid_o` is 1, whatever the select value.
- R10: Bits 7:5 of the control register have no effect on the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gmask_i | input | 1 | CPU global interrupt mask (1 = inhibited) |
| req_i | input | N_SRC | Per-source request |
| en_i | input | N_SRC | Per-source local enable |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| ctrl_o | output | 8 | Control register contents |
| irq_valid_o | output | 1 | A source is presented |
| irq_idx_o | output | IDX_W | Winning source index |
| irq_vec_o | output | 16 | Vector address of the winner |

## Verification
All requests are raised together with each legal select value in turn. This separates promotion from the fixed order: with every line pending, only promotion can make a source other than 0 win. Select values of N_SRC and above, and the same pattern with the promoted enable cleared, show whether the design falls back to the lowest index. A sweep of the select value with a single fixed source pending shows whether the vector follows the index or the select. Random request, enable, mask and write patterns, including writes with the mask clear, exercise the write protection and the upper register bits against a bench model.

// File: rtl/irqres_pkg.sv
package irqres_pkg;
  localparam int SEL_W = 5;
  localparam int VEC_W = 16;
  localparam logic [7:0] CTRL_RST = 8'h06;

  // vector address for a source index: descending 2-byte slots from the top
  function automatic logic [VEC_W-1:0] vec_of(input logic [VEC_W-1:0] top,
                                               input int unsigned idx);
    return top - VEC_W'(idx * 2);
  endfunction
endpackage

// File: rtl/irqres_ctrl_reg.sv
module irqres_ctrl_reg
  import irqres_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gmask_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] ctrl_o
);
  logic [2:0]       mode_q;
  logic [SEL_W-1:0] sel_q;
  logic             sel_wr_ok;

  assign sel_wr_ok = wr_en_i & gmask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= CTRL_RST[7:5];
    else if (wr_en_i) mode_q <= wr_data_i[7:5];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= CTRL_RST[4:0];
    else if (sel_wr_ok) sel_q <= wr_data_i[4:0];
  end

  assign ctrl_o = {mode_q, sel_q};
endmodule

// File: rtl/irqres_fixed_pick.sv
module irqres_fixed_pick #(
  parameter int N_SRC = 20,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] act_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
  import irqres_pkg::*;
#(
  parameter int N_SRC = 20,
  parameter logic [15:0] VEC_TOP = 16'hFFD6,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gmask_i,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       ctrl_o,
  output logic             irq_valid_o,
  output logic [IDX_W-1:0] irq_idx_o,
  output logic [15:0]      irq_vec_o
);
  logic [SEL_W-1:0] sel_q;
  logic [N_SRC-1:0] act;
  logic             fixed_found;
  logic [IDX_W-1:0] fixed_idx;
  logic             promo_hit;
  logic [IDX_W-1:0] win_idx;

  irqres_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .gmask_i(gmask_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .ctrl_o(ctrl_o)
  );

  assign sel_q = ctrl_o[4:0];
  assign act   = req_i & en_i & {N_SRC{~gmask_i}};

  irqres_fixed_pick #(.N_SRC(N_SRC)) u_pick (
    .act_i(act), .found_o(fixed_found), .idx_o(fixed_idx)
  );

  // promotion: select matches an implemented, active source
  always_comb begin
    promo_hit = 1'b0;
    for (int i = 0; i < N_SRC; i++) begin
      if (sel_q == SEL_W'(i) && act[i]) promo_hit = 1'b1;
    end
  end

  assign win_idx     = promo_hit ? IDX_W'(sel_q) : fixed_idx;
  assign irq_valid_o = fixed_found;
  assign irq_idx_o   = fixed_found ? win_idx : '0;
  assign irq_vec_o   = fixed_found ? vec_of(VEC_TOP, int'(win_idx)) : '0;
endmodule

// File: rtl/irqres_chk.sv
module irqres_chk
  import irqres_pkg::*;
#(
  parameter int N_SRC = 20,
  parameter logic [15:0] VEC_TOP = 16'hFFD6,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gmask_i,
  input logic [N_SRC-1:0] req_i,
  input logic [N_SRC-1:0] en_i,
  input logic             wr_en_i,
  input logic [7:0]       wr_data_i,
  input logic [7:0]       ctrl_o,
  input logic             irq_valid_o,
  input logic [IDX_W-1:0] irq_idx_o,
  input logic [15:0]      irq_vec_o,
  input logic             promo_hit
);
  logic [N_SRC-1:0] chk_act;
  logic [N_SRC-1:0] below_win;
  assign chk_act   = req_i & en_i & {N_SRC{~gmask_i}};
  assign below_win = ~({N_SRC{1'b1}} << irq_idx_o);

  // R2
  masked_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && gmask_i) |=> (ctrl_o == $past(wr_data_i)));
  // R3
  open_write_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && !gmask_i) |=> (ctrl_o[4:0] == $past(ctrl_o[4:0])));
  // R4
  valid_matches_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o == (|chk_act));
  // R6
  promoted_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    promo_hit |-> (irq_valid_o && 32'(irq_idx_o) == 32'(ctrl_o[4:0])));
  // R5
  fixed_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !promo_hit) |-> ((chk_act & below_win) == '0));
  // R9
  vec_follows_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> (irq_vec_o == vec_of(VEC_TOP, int'(irq_idx_o))));
endmodule

bind irq_prio_resolver irqres_chk #(.N_SRC(N_SRC), .VEC_TOP(VEC_TOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .gmask_i(gmask_i), .req_i(req_i), .en_i(en_i),
  .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .ctrl_o(ctrl_o),
  .irq_valid_o(irq_valid_o), .irq_idx_o(irq_idx_o), .irq_vec_o(irq_vec_o),
  .promo_hit(promo_hit)
);

// File: tb/irq_prio_resolver_bench.sv
module irq_prio_resolver_bench;
  localparam int N = 20;
  localparam int IW = 5;
  localparam logic [15:0] TOP = 16'hFFD6;

  logic clk = 0, rst_n = 0, gmask = 1, wr_en = 0;
  logic [N-1:0] req = '0, en = '0;
  logic [7:0] wr_data = '0, ctrl;
  logic valid;
  logic [IW-1:0] idx;
  logic [15:0] vec;
  int checks = 0, fails = 0;
  logic [7:0] model_ctrl;

  always #4 clk = ~clk;

  irq_prio_resolver #(.N_SRC(N), .VEC_TOP(TOP)) u_irq_prio_resolver (
    .clk(clk), .rst_n(rst_n), .gmask_i(gmask), .req_i(req), .en_i(en),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .ctrl_o(ctrl),
    .irq_valid_o(valid), .irq_idx_o(idx), .irq_vec_o(vec));

  function automatic int exp_win(input logic [N-1:0] r, input logic [N-1:0] e,
                                 input logic m, input logic [7:0] c);
    int s = int'(c[4:0]);
    if (m) return -1;
    if (s < N && r[s] && e[s]) return s;
    for (int i = 0; i < N; i++) if (r[i] && e[i]) return i;
    return -1;
  endfunction

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_out(input string tag);
    int w;
    #1;
    w = exp_win(req, en, gmask, model_ctrl);
    cmp({tag, " valid"}, 32'(valid), 32'(w >= 0));
    cmp({tag, " idx"}, 32'(idx), (w >= 0) ? 32'(w) : 0);
    cmp({tag, " vec"}, 32'(vec), (w >= 0) ? 32'(TOP - 16'(w * 2)) : 0);
  endtask

  task automatic wr(input logic [7:0] d, input logic m);
    @(negedge clk);
    gmask = m; wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    model_ctrl[7:5] = d[7:5];
    if (m) model_ctrl[4:0] = d[4:0];
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_ctrl = 8'h06;
    #20;
    // R1 reset value
    cmp("R1 ctrl reset", 32'(ctrl), 32'h06);
    rst_n = 1;
    @(negedge clk);
    cmp("R1 ctrl after release", 32'(ctrl), 32'h06);

    // R6 every legal select promoted with all pending
    for (int s = 0; s < N; s++) begin
      wr(8'(s), 1'b1);
      cmp("R2 ctrl write", 32'(ctrl), 32'(s));
      gmask = 0; req = '1; en = '1;
      check_out("R6 promote all");
      // R7 promoted enable clear falls back
      en[s] = 1'b0;
      check_out("R7 promoted enable off");
      gmask = 1;
      check_out("R7 global mask");
      en = '1; req = '0;
    end

    // R8 out-of-range selects
    for (int s = N; s < 32; s++) begin
      wr(8'(s), 1'b1);
      gmask = 0; req = '1; en = '1;
      req[0] = 0;
      check_out("R8 no promotion");
      req = '0;
    end

    // R3 write with mask clear keeps select, R10 upper bits no effect
    wr(8'h03, 1'b1);
    wr(8'hE9, 1'b0);
    cmp("R3 sel kept", 32'(ctrl), 32'hE3);
    gmask = 0; req = 20'h0000A; en = '1;
    check_out("R10 upper bits set");
    wr(8'h03, 1'b1);
    gmask = 0;
    check_out("R10 upper bits clear");

    // R9 vector independent of select: single source 7 pending
    for (int s = 0; s < 32; s++) begin
      wr(8'(s), 1'b1);
      gmask = 0; req = '0; req[7] = 1; en = '1;
      #1;
      cmp("R9 vector fixed", 32'(vec), 32'(TOP - 16'd14));
    end

    // random mix (R4, R5, R2, R3)
    for (int k = 0; k < 400; k++) begin
      if ($urandom % 4 == 0) wr(8'($urandom), 1'($urandom));
      @(negedge clk);
      req = N'($urandom); en = N'($urandom);
      gmask = ($urandom % 5 == 0);
      check_out("R4/R5 random");
      cmp("R2/R3 random ctrl", 32'(ctrl), 32'(model_ctrl));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule